// File: doc/BRIEF.md
# Display EDID Fetch and Checksum Checker

This block reads a monitor's identification data (EDID) through a separate transaction engine. It first reads the sink's 12-byte capability region over the native channel. If that read fails, it waits a set number of cycles and tries again, up to five more times. It then runs a fetch attempt over the I2C channel at device address 0x50:

- read the extension-count byte;
- read the 128-byte base block;
- if the extension count is nonzero, read the second 128-byte block.

Each byte read from a block is written into a local 256-byte buffer as it arrives, and added to a running 8-bit sum. A block is accepted only if it has exactly 128 bytes and a sum of zero.

After the blocks are accepted, the block reads the sink's test-request register. If the sink asks for an EDID-read test, the block writes the checksum byte of the last fetched block to the sink. It then writes the response code. Any transfer error or bad block ends the attempt, and the block starts a new attempt. Up to three attempts are made. The result is reported on level flags that hold until the next start.

Top module: `edid_fetch`

## Requirements
- R1: After reset and whenever idle, `busy_o`, `done_o`, `fail_o`, `req_start_o` and `buf_we_o` are all low.
- R2: Each run begins with a native read at address 0x000 of length 12. No I2C read is issued until such a read ends without error. After an erroring capability read the next one starts no sooner than `CAP_GAP_CYCLES` cycles later. After 6 erroring capability reads the run ends with `fail_o`, and no EDID read has been made.
- R3: Every fetch attempt begins with an I2C read at device 0x50, offset 126, length 1. That byte is the extension count.
- R4: The base block is an I2C read at offset 0, length 128, stored at buffer addresses 0..127. Only when the extension count is nonzero, a second read at offset 128, length 128, is stored at addresses 128..255.
- R5: A block is valid only if exactly 128 bytes arrive, no error is flagged, and the 8-bit wrapping sum of its bytes is zero. An invalid block ends the attempt.
- R6: Any transfer error or invalid block ends the current attempt and starts a new one from R3. This happens at most 3 attempts per run, after which `fail_o` is set. The first successful attempt ends the run.
- R7: After valid blocks, a native read of address 0x218 (length 1) is made. If bit 2 of that byte is set, the block writes the checksum byte of the last fetched block to 0x261, then writes 0x04 to 0x260. Otherwise no write is made.
- R8: `done_o` (success) and `fail_o` are never high together. Both are cleared by an accepted start and hold until the next one. `start_i` is ignored while `busy_o` is high.
- R9: `req_start_o` pulses exactly once per transfer, and never while a transfer is outstanding. Request fields are stable until `xfer_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a fetch run (ignored while busy) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run succeeded |
| fail_o | output | 1 | Last run failed |
| req_start_o | output | 1 | One-cycle pulse launching a transfer |
| req_i2c_o | output | 1 | 1 = I2C channel, 0 = native register channel |
| req_write_o | output | 1 | 1 = one-byte write, 0 = read |
| req_dev_o | output | 7 | I2C device address |
| req_addr_o | output | 16 | Register address or I2C offset |
| req_len_o | output | 8 | Bytes to read |
| req_wdata_o | output | 8 | Byte to write |
| rd_valid_i | input | 1 | A read byte is present |
| rd_data_i | input | 8 | Read byte |
| xfer_done_i | input | 1 | Transfer finished (one-cycle pulse) |
| xfer_err_i | input | 1 | Transfer failed, valid with `xfer_done_i` |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 8 | Buffer write address |
| buf_data_o | output | 8 | Buffer write data |

## Verification
The assertions assume the engine behaves as follows:

- It raises `xfer_done_i` once per launched transfer.
- It delivers read bytes only while a transfer is outstanding.
- It delivers the last byte in a cycle strictly before the done pulse.

The bench engine keeps to this. It waits a cycle after each launch, and spaces bytes with random idle cycles. It raises done only on the cycle after the final byte. It injects faults only through the error flag, a flipped byte, or a block one byte short.

// File: rtl/edid_pkg.sv
package edid_pkg;
    localparam int          BLOCK_BYTES    = 128;
    localparam int          BUF_AW         = $clog2(BLOCK_BYTES) + 1;
    localparam int          CAP_LEN        = 12;
    localparam logic [6:0]  EDID_DEV       = 7'h50;
    localparam logic [15:0] EXT_COUNT_OFS  = 16'd126;
    localparam logic [15:0] REG_TEST_REQ   = 16'h0218;
    localparam logic [15:0] REG_TEST_CSUM  = 16'h0261;
    localparam logic [15:0] REG_TEST_RESP  = 16'h0260;
    localparam int          TEST_EDID_BIT  = 2;
    localparam logic [7:0]  RESP_CSUM_DONE = 8'h04;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CAP, ST_GAP, ST_EXT, ST_BLK, ST_TREQ, ST_WCSUM, ST_WRESP
    } fetch_state_e;

    typedef struct packed {
        logic        i2c;
        logic        wr;
        logic [6:0]  dev;
        logic [15:0] addr;
        logic [7:0]  len;
        logic [7:0]  wdata;
    } xfer_req_t;

    function automatic xfer_req_t req_for(fetch_state_e st, logic blk, logic [7:0] csum);
        xfer_req_t r;
        r = '0;
        case (st)
            ST_CAP:   begin r.len = 8'(CAP_LEN); end
            ST_EXT:   begin r.i2c = 1'b1; r.dev = EDID_DEV; r.addr = EXT_COUNT_OFS; r.len = 8'd1; end
            ST_BLK:   begin r.i2c = 1'b1; r.dev = EDID_DEV; r.addr = blk ? 16'(BLOCK_BYTES) : 16'd0;
                            r.len = 8'(BLOCK_BYTES); end
            ST_TREQ:  begin r.addr = REG_TEST_REQ; r.len = 8'd1; end
            ST_WCSUM: begin r.wr = 1'b1; r.addr = REG_TEST_CSUM; r.len = 8'd1; r.wdata = csum; end
            ST_WRESP: begin r.wr = 1'b1; r.addr = REG_TEST_RESP; r.len = 8'd1; r.wdata = RESP_CSUM_DONE; end
            default:  r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/edid_byte_acc.sv
module edid_byte_acc #(
    parameter int NBYTES = 128
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          clr_i,
    input  logic                          vld_i,
    input  logic [7:0]                    data_i,
    output logic [7:0]                    sum_o,
    output logic [$clog2(NBYTES+2)-1:0]   count_o,
    output logic [7:0]                    first_o,
    output logic [7:0]                    last_o
);
    localparam int CW = $clog2(NBYTES + 2);
    localparam logic [CW-1:0] CMAX = CW'(NBYTES + 1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sum_o   <= '0;
            count_o <= '0;
            first_o <= '0;
            last_o  <= '0;
        end else if (clr_i) begin
            sum_o   <= '0;
            count_o <= '0;
            first_o <= '0;
        end else if (vld_i) begin
            sum_o <= sum_o + data_i;
            if (count_o != CMAX) count_o <= count_o + 1'b1;
            if (count_o == '0) first_o <= data_i;
            if (count_o == CW'(NBYTES - 1)) last_o <= data_i;
        end
    end
endmodule

// File: rtl/edid_try_ctr.sv
module edid_try_ctr #(
    parameter int LIMIT = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) cnt_q <= '0;
        else if (inc_i)     cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/edid_gap_timer.sv
module edid_gap_timer #(
    parameter int CYCLES = 2_500_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    output logic zero_o
);
    localparam int W = $clog2(CYCLES + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)              cnt_q <= '0;
        else if (load_i)        cnt_q <= W'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
    import edid_pkg::*;
#(
    parameter int CAP_RETRIES    = 5,
    parameter int FETCH_ATTEMPTS = 3,
    parameter int CAP_GAP_CYCLES = 2_500_000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              req_start_o,
    output logic              req_i2c_o,
    output logic              req_write_o,
    output logic [6:0]        req_dev_o,
    output logic [15:0]       req_addr_o,
    output logic [7:0]        req_len_o,
    output logic [7:0]        req_wdata_o,
    input  logic              rd_valid_i,
    input  logic [7:0]        rd_data_i,
    input  logic              xfer_done_i,
    input  logic              xfer_err_i,
    output logic              buf_we_o,
    output logic [BUF_AW-1:0] buf_addr_o,
    output logic [7:0]        buf_data_o
);
    localparam int CNT_W = $clog2(BLOCK_BYTES + 2);
    localparam int IDX_W = BUF_AW - 1;

    fetch_state_e st_q, st_d;
    logic launch_q, launch_d;
    logic blk_q, blk_d, extnz_q, extnz_d;
    logic [7:0] csum_q, csum_d;
    logic done_d, fail_d;
    logic cap_clr, cap_inc, cap_last, att_clr, att_inc, att_last;
    logic gap_load, gap_zero, retry, finish, blk_ok;
    logic [7:0] acc_sum, acc_first, acc_last;
    logic [CNT_W-1:0] acc_cnt;
    xfer_req_t req;

    edid_byte_acc #(.NBYTES(BLOCK_BYTES)) u_acc (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(launch_q), .vld_i(rd_valid_i), .data_i(rd_data_i),
        .sum_o(acc_sum), .count_o(acc_cnt), .first_o(acc_first), .last_o(acc_last)
    );

    edid_try_ctr #(.LIMIT(CAP_RETRIES + 1)) u_cap_ctr (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(cap_clr), .inc_i(cap_inc), .last_o(cap_last)
    );

    edid_try_ctr #(.LIMIT(FETCH_ATTEMPTS)) u_att_ctr (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(att_clr), .inc_i(att_inc), .last_o(att_last)
    );

    edid_gap_timer #(.CYCLES(CAP_GAP_CYCLES)) u_gap (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(gap_load), .zero_o(gap_zero)
    );

    assign blk_ok = !xfer_err_i && (acc_sum == 8'd0) && (acc_cnt == CNT_W'(BLOCK_BYTES));

    always_comb begin
        st_d = st_q; launch_d = 1'b0; blk_d = blk_q; extnz_d = extnz_q; csum_d = csum_q;
        done_d = done_o; fail_d = fail_o;
        cap_clr = 1'b0; cap_inc = 1'b0; att_clr = 1'b0; att_inc = 1'b0;
        gap_load = 1'b0; retry = 1'b0; finish = 1'b0;
        case (st_q)
            ST_IDLE: if (start_i) begin
                st_d = ST_CAP; launch_d = 1'b1; done_d = 1'b0; fail_d = 1'b0;
                cap_clr = 1'b1; att_clr = 1'b1;
            end
            ST_CAP: if (xfer_done_i) begin
                if (!xfer_err_i)   begin st_d = ST_EXT; launch_d = 1'b1; end
                else if (cap_last) begin st_d = ST_IDLE; fail_d = 1'b1; end
                else               begin cap_inc = 1'b1; gap_load = 1'b1; st_d = ST_GAP; end
            end
            ST_GAP: if (gap_zero) begin st_d = ST_CAP; launch_d = 1'b1; end
            ST_EXT: if (xfer_done_i) begin
                if (xfer_err_i) retry = 1'b1;
                else begin
                    extnz_d = (acc_first != 8'd0); blk_d = 1'b0;
                    st_d = ST_BLK; launch_d = 1'b1;
                end
            end
            ST_BLK: if (xfer_done_i) begin
                if (!blk_ok) retry = 1'b1;
                else begin
                    csum_d = acc_last; launch_d = 1'b1;
                    if (!blk_q && extnz_q) blk_d = 1'b1;
                    else                   st_d = ST_TREQ;
                end
            end
            ST_TREQ: if (xfer_done_i) begin
                if (xfer_err_i)                   retry = 1'b1;
                else if (acc_first[TEST_EDID_BIT]) begin st_d = ST_WCSUM; launch_d = 1'b1; end
                else                              finish = 1'b1;
            end
            ST_WCSUM: if (xfer_done_i) begin
                if (xfer_err_i) retry = 1'b1;
                else begin st_d = ST_WRESP; launch_d = 1'b1; end
            end
            ST_WRESP: if (xfer_done_i) begin
                if (xfer_err_i) retry = 1'b1;
                else            finish = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
        if (retry) begin
            if (att_last) begin st_d = ST_IDLE; fail_d = 1'b1; end
            else          begin att_inc = 1'b1; st_d = ST_EXT; launch_d = 1'b1; end
        end
        if (finish) begin st_d = ST_IDLE; done_d = 1'b1; end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= ST_IDLE; launch_q <= 1'b0; blk_q <= 1'b0; extnz_q <= 1'b0;
            csum_q <= '0; done_o <= 1'b0; fail_o <= 1'b0;
        end else begin
            st_q <= st_d; launch_q <= launch_d; blk_q <= blk_d; extnz_q <= extnz_d;
            csum_q <= csum_d; done_o <= done_d; fail_o <= fail_d;
        end
    end

    assign req         = req_for(st_q, blk_q, csum_q);
    assign busy_o      = (st_q != ST_IDLE);
    assign req_start_o = launch_q;
    assign req_i2c_o   = req.i2c;
    assign req_write_o = req.wr;
    assign req_dev_o   = req.dev;
    assign req_addr_o  = req.addr;
    assign req_len_o   = req.len;
    assign req_wdata_o = req.wdata;

    assign buf_we_o   = rd_valid_i && (st_q == ST_BLK) && (acc_cnt < CNT_W'(BLOCK_BYTES));
    assign buf_addr_o = {blk_q, acc_cnt[IDX_W-1:0]};
    assign buf_data_o = rd_data_i;
endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       fail_o,
    input logic       req_start_o,
    input logic       req_i2c_o,
    input logic [6:0] req_dev_o,
    input logic       xfer_done_i,
    input logic       buf_we_o
);
    logic outst_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)            outst_q <= 1'b0;
        else if (req_start_o) outst_q <= 1'b1;
        else if (xfer_done_i) outst_q <= 1'b0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (!req_start_o && !buf_we_o));
    a_r3_edid_device: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_start_o && req_i2c_o) |-> (req_dev_o == 7'h50));
    a_r4_store_in_xfer: assert property (@(posedge clk_i) disable iff (rst_i)
        buf_we_o |-> outst_q);
    a_r6_end_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(done_o) || $rose(fail_o)) |-> !busy_o);
    a_r8_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && fail_o));
    a_r8_hold_done: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> done_o);
    a_r8_hold_fail: assert property (@(posedge clk_i) disable iff (rst_i)
        (fail_o && !start_i) |=> fail_o);
    a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
        req_start_o |-> !outst_q);
endmodule

bind edid_fetch edid_fetch_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .req_start_o(req_start_o), .req_i2c_o(req_i2c_o), .req_dev_o(req_dev_o),
    .xfer_done_i(xfer_done_i), .buf_we_o(buf_we_o)
);

// File: tb/edid_fetch_tb.sv
`timescale 1ns/1ps
module edid_fetch_tb_top;
    localparam int GAP = 20;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic busy, done, fail, req_start, req_i2c, req_write;
    logic [6:0] req_dev;
    logic [15:0] req_addr;
    logic [7:0] req_len, req_wdata, rd_data, buf_data;
    logic rd_valid, xdone, xerr, buf_we;
    logic [7:0] buf_addr;

    always #2 clk = ~clk;

    edid_fetch #(.CAP_RETRIES(5), .FETCH_ATTEMPTS(3), .CAP_GAP_CYCLES(GAP)) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .busy_o(busy), .done_o(done), .fail_o(fail),
        .req_start_o(req_start), .req_i2c_o(req_i2c), .req_write_o(req_write), .req_dev_o(req_dev),
        .req_addr_o(req_addr), .req_len_o(req_len), .req_wdata_o(req_wdata),
        .rd_valid_i(rd_valid), .rd_data_i(rd_data), .xfer_done_i(xdone), .xfer_err_i(xerr),
        .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] edid [256];
    logic [7:0] bbuf [256];
    logic [7:0] treq_val;
    logic [1:0] fc [32];
    int tcnt, cap_reads, wr_cnt, cap_err_cyc;
    bit cap_err_pend, cap_ok_seen;
    logic [15:0] wa [2];
    logic [7:0]  wd [2];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // buffer monitor, sampled one ns before the rising edge
    always @(negedge clk) begin
        #1;
        if (buf_we) bbuf[buf_addr] = buf_data;
    end

    // transaction engine model
    initial begin
        rd_valid = 0; rd_data = 0; xdone = 0; xerr = 0;
        forever begin
            @(negedge clk);
            xdone = 0; xerr = 0;
            if (req_start && !rst) begin
                logic [1:0] f;
                logic i2c, wr;
                logic [15:0] a;
                logic [7:0] ln, b;
                int n;
                bit is_cap;
                f = (tcnt < 32) ? fc[tcnt] : 2'd0;
                tcnt++;
                i2c = req_i2c; wr = req_write; a = req_addr; ln = req_len;
                is_cap = !i2c && !wr && a == 16'h0;
                if (is_cap) begin
                    cap_reads++;
                    check(ln == 8'd12, "R2", "capability length", ln, 12);
                    if (cap_err_pend)
                        check(cyc - cap_err_cyc >= GAP, "R2", "retry spacing", cyc - cap_err_cyc, GAP);
                end
                if (i2c) begin
                    check(cap_ok_seen, "R2", "EDID read before capability ok", 0, 1);
                    check(req_dev == 7'h50, "R3", "device address", req_dev, 'h50);
                    if (ln == 8'd1) check(a == 16'd126, "R3", "extension offset", a, 126);
                    else check(ln == 8'd128 && (a == 16'd0 || a == 16'd128), "R4", "block request", a, 0);
                end
                if (wr) begin
                    wr_cnt++;
                    wa[0] = wa[1]; wd[0] = wd[1];
                    wa[1] = a;     wd[1] = req_wdata;
                end
                @(negedge clk);
                if (!wr) begin
                    n = ln;
                    if (f == 2'd3 && ln == 8'd128) n = ln - 1;
                    for (int i = 0; i < n; i++) begin
                        if (i2c)                b = edid[8'(a + 16'(i))];
                        else if (a == 16'h0218) b = treq_val;
                        else                    b = 8'(i * 7 + 1);
                        if (f == 2'd2 && ln == 8'd128 && i == 5) b = b ^ 8'h10;
                        rd_valid = 1; rd_data = b;
                        @(negedge clk);
                        rd_valid = 0;
                        if ($urandom_range(0, 3) == 0) @(negedge clk);
                    end
                end
                xdone = 1; xerr = (f == 2'd1);
                if (is_cap) begin
                    if (f == 2'd1) begin cap_err_pend = 1; cap_err_cyc = cyc; end
                    else begin cap_err_pend = 0; cap_ok_seen = 1; end
                end
            end
        end
    end

    // reference model of the run, from the requirements
    task automatic model(input bit ext, input bit treq, output bit ok, output int ntx,
                         output int ncap, output int nwr);
        int t = 0;
        bit cap_good = 0;
        ok = 0; ncap = 0; nwr = 0;
        for (int k = 0; k < 6 && !cap_good; k++) begin
            ncap++;
            if (fc[t] != 2'd1) cap_good = 1;
            t++;
        end
        if (cap_good) begin
            for (int att = 0; att < 3 && !ok; att++) begin
                bit bad = 0;
                if (fc[t++] == 2'd1) continue;
                for (int b = 0; b < (ext ? 2 : 1) && !bad; b++) if (fc[t++] != 2'd0) bad = 1;
                if (bad) continue;
                if (fc[t++] == 2'd1) continue;
                if (treq) begin
                    nwr++;
                    if (fc[t++] == 2'd1) continue;
                    nwr++;
                    if (fc[t++] == 2'd1) continue;
                end
                ok = 1;
            end
        end
        ntx = t;
    endtask

    task automatic fill_block(input int base, input logic [7:0] extv);
        logic [7:0] s = 0;
        for (int i = 0; i < 127; i++) begin
            edid[base + i] = (i == 126) ? extv : 8'($urandom);
            s += edid[base + i];
        end
        edid[base + 127] = -s;
    endtask

    task automatic run_case(input string name, input bit ext, input bit treq, input bit poke);
        bit ok, to;
        int ntx, ncap, nwr, nb;
        fill_block(0, ext ? 8'($urandom_range(1, 255)) : 8'd0);
        fill_block(128, 8'($urandom));
        treq_val = treq ? (8'($urandom) | 8'h04) : (8'($urandom) & 8'hFB);
        for (int i = 0; i < 256; i++) bbuf[i] = 8'hEE;
        tcnt = 0; cap_reads = 0; wr_cnt = 0; cap_err_pend = 0; cap_ok_seen = 0;
        wa[0] = 0; wa[1] = 0; wd[0] = 0; wd[1] = 0;
        model(ext, treq, ok, ntx, ncap, nwr);
        nb = ext ? 2 : 1;
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
        end
        to = 1;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (!busy) begin to = 0; break; end
        end
        if (to) begin
            check(0, "R6", {name, " run hung"}, 0, 1);
            return;
        end
        repeat (5) @(negedge clk);
        #1;
        check(done == ok, "R8", {name, " done flag"}, done, ok);
        check(fail == !ok, "R8", {name, " fail flag"}, fail, !ok);
        check(!busy, "R8", {name, " stays idle"}, busy, 0);
        check(tcnt == ntx, "R6 R9", {name, " transfer count"}, tcnt, ntx);
        check(cap_reads == ncap, "R2", {name, " capability reads"}, cap_reads, ncap);
        check(wr_cnt == nwr, "R7", {name, " write count"}, wr_cnt, nwr);
        if (ok) begin
            int bad = 0;
            for (int i = 0; i < nb * 128; i++) if (bbuf[i] !== edid[i]) bad++;
            if (!ext) for (int i = 128; i < 256; i++) if (bbuf[i] !== 8'hEE) bad++;
            check(bad == 0, "R4 R5", {name, " buffer bytes wrong"}, bad, 0);
        end
        if (ok && treq) begin
            check(wa[0] == 16'h0261, "R7", {name, " checksum reg"}, wa[0], 'h261);
            check(wd[0] == edid[nb * 128 - 1], "R7", {name, " checksum byte"}, wd[0], edid[nb * 128 - 1]);
            check(wa[1] == 16'h0260 && wd[1] == 8'h04, "R7", {name, " response"}, wd[1], 4);
        end
    endtask

    task automatic clear_faults();
        for (int i = 0; i < 32; i++) fc[i] = 2'd0;
    endtask

    initial begin
        void'($urandom(32'h5EED_ED1D));
        clear_faults();
        repeat (4) @(negedge clk);
        #1;
        check(!busy && !done && !fail && !req_start && !buf_we, "R1", "reset state", busy, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        #1;
        check(!req_start && !busy, "R1", "idle after reset", req_start, 0);

        clear_faults(); run_case("base only", 0, 0, 0);
        clear_faults(); run_case("ext+test, start while busy", 1, 1, 1);
        clear_faults(); for (int i = 0; i < 5; i++) fc[i] = 2'd1;
        run_case("cap 5 errors", 1, 0, 0);
        clear_faults(); for (int i = 0; i < 6; i++) fc[i] = 2'd1;
        run_case("cap 6 errors", 0, 1, 0);
        clear_faults(); fc[2] = 2'd2; fc[5] = 2'd3;
        run_case("bad sum then short", 1, 0, 0);
        clear_faults(); fc[1] = 2'd1; fc[3] = 2'd2; fc[5] = 2'd1;
        run_case("three bad attempts", 0, 0, 0);
        clear_faults(); fc[3] = 2'd1; fc[9] = 2'd1;
        run_case("test path errors", 0, 1, 0);

        for (int r = 0; r < 24; r++) begin
            for (int i = 0; i < 32; i++)
                fc[i] = ($urandom_range(0, 99) < 15) ? 2'($urandom_range(1, 3)) : 2'd0;
            run_case("random", 1'($urandom), 1'($urandom), 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 190000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule